// File: doc/BRIEF.md
# DMA Request Page Splitter

This block takes one inbound DMA request and turns it into a series of memory-access commands. None of these commands crosses an 8 KiB page edge. A request carries:

- a direction (read or write);
- an address mode (32-bit or 64-bit);
- a start address;
- a length in dwords;
- an 8-bit byte-enable field;
- a requester id.

The block first works out the total byte count. It then issues chunk commands one at a time. Each chunk command is held until the downstream side accepts it. Each accepted chunk is answered by a single ok/fail response.

Data movement and address translation are handled elsewhere. This block only plans the chunks, sequences them, and folds their results together. When the last response arrives, it raises a one-cycle completion. The completion carries a 3-bit status: successful or completer abort.

Top module: `dma_page_splitter`

## Requirements
- R1: When the dword length is 0, 1 or 2, the total byte count equals the number of set bits in the 8-bit byte-enable field.
- R2: When the dword length is greater than 2, the total byte count is the byte-enable popcount plus (length - 2) * 4.
- R3: No chunk crosses an 8 KiB page edge. Each chunk size is the smaller of the bytes still remaining and 8192 - (address mod 8192).
- R4: Chunks are issued in ascending address order. The first chunk starts at the request address, and each later chunk starts where the previous one ended. The chunk sizes add up to the total byte count.
- R5: Every chunk carries the request's direction (`chunk_write`: 1 = write), address mode (`chunk_addr64`: 1 = 64-bit) and requester id, unchanged.
- R6: A chunk command is held stable until `chunk_ready` is seen. At most one chunk is outstanding. The next chunk is offered only after the response to the previous one.
- R7: The completion status is 3'b000 (successful) if every chunk response had `rsp_ok` = 1, and 3'b100 (completer abort) otherwise. A failed chunk does not stop the remaining chunks from being issued.
- R8: A request whose total byte count is zero issues no chunk. It completes with status 3'b000 one cycle after acceptance.
- R9: After reset, `req_ready` is 1 and `chunk_valid` and `cpl_valid` are 0. `req_ready` is 1 only while no request is in progress.
- R10: `cpl_valid` is a single-cycle pulse. It is raised in the cycle after the last chunk response, and the block is ready for a new request the cycle after that.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted when valid |
| req_write | input | 1 | Direction, 1 = write |
| req_addr64 | input | 1 | Address mode, 1 = 64-bit |
| req_addr | input | ADDR_W | Start byte address |
| req_len_dw | input | LEN_W | Length in dwords |
| req_be | input | 8 | Byte-enable field |
| req_rid | input | RID_W | Requester id |
| chunk_valid | output | 1 | Chunk command offered |
| chunk_ready | input | 1 | Downstream accepts the chunk |
| chunk_write | output | 1 | Direction of the chunk |
| chunk_addr64 | output | 1 | Address mode of the chunk |
| chunk_addr | output | ADDR_W | Chunk start address |
| chunk_bytes | output | SIZE_W | Chunk byte count |
| chunk_rid | output | RID_W | Requester id of the chunk |
| rsp_valid | input | 1 | Response for the outstanding chunk |
| rsp_ok | input | 1 | 1 = chunk succeeded |
| cpl_valid | output | 1 | Completion pulse |
| cpl_status | output | 3 | 000 successful, 100 completer abort |

## Verification
The requests are chosen to separate the two halves of the size formula:

- short lengths with sparse byte enables test the popcount alone;
- long lengths add the dword term.

The page-split logic is tested with several start addresses:

- a page-aligned start that fits in one page;
- a start that ends exactly on a page edge, which must stay a single chunk;
- starts just below an edge, including one with a 64-bit address and the maximum length, which must produce two chunks with the correct split point.

Two further cases cover failures and the empty request:

- failure injected on the second chunk, which tells status folding apart from early termination;
- an all-zero byte enable, which checks the empty-request shortcut.

// File: rtl/dps_pkg.sv
package dps_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_DONE  = 2'd3
    } dps_state_e;

    localparam logic [2:0] CPL_SUCCESS = 3'b000;
    localparam logic [2:0] CPL_ABORT   = 3'b100;

endpackage

// File: rtl/dps_byte_count.sv
module dps_byte_count #(
    parameter int LEN_W = 10,
    parameter int CNT_W = 13
) (
    input  logic [7:0]       be,
    input  logic [LEN_W-1:0] len_dw,
    output logic [CNT_W-1:0] total
);
    logic [3:0]       ones;
    logic [CNT_W-1:0] extra;

    always_comb begin
        ones = '0;
        for (int i = 0; i < 8; i++) begin
            ones = ones + {3'b000, be[i]};
        end
        if (len_dw > LEN_W'(2)) begin
            extra = CNT_W'(len_dw - LEN_W'(2)) << 2;
        end else begin
            extra = '0;
        end
        total = extra + CNT_W'(ones);
    end
endmodule

// File: rtl/dps_chunk_calc.sv
module dps_chunk_calc #(
    parameter int ADDR_W     = 64,
    parameter int PAGE_SHIFT = 13,
    parameter int CNT_W      = 13,
    parameter int SIZE_W     = 14
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  remain,
    output logic [SIZE_W-1:0] size
);
    localparam logic [SIZE_W-1:0] PAGE_BYTES = SIZE_W'(1) << PAGE_SHIFT;

    logic [SIZE_W-1:0] room;
    logic [SIZE_W-1:0] remain_w;

    always_comb begin
        room     = PAGE_BYTES - SIZE_W'(addr[PAGE_SHIFT-1:0]);
        remain_w = SIZE_W'(remain);
        size     = (remain_w < room) ? remain_w : room;
    end
endmodule

// File: rtl/dma_page_splitter.sv
module dma_page_splitter
    import dps_pkg::*;
#(
    parameter int ADDR_W     = 64,
    parameter int LEN_W      = 10,
    parameter int RID_W      = 16,
    parameter int PAGE_SHIFT = 13,
    localparam int CNT_W     = LEN_W + 3,
    localparam int SIZE_W    = (CNT_W > PAGE_SHIFT + 1) ? CNT_W : PAGE_SHIFT + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic              req_addr64,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len_dw,
    input  logic [7:0]        req_be,
    input  logic [RID_W-1:0]  req_rid,
    output logic              chunk_valid,
    input  logic              chunk_ready,
    output logic              chunk_write,
    output logic              chunk_addr64,
    output logic [ADDR_W-1:0] chunk_addr,
    output logic [SIZE_W-1:0] chunk_bytes,
    output logic [RID_W-1:0]  chunk_rid,
    input  logic              rsp_valid,
    input  logic              rsp_ok,
    output logic              cpl_valid,
    output logic [2:0]        cpl_status
);

    typedef struct packed {
        dps_state_e        st;
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  remain;
        logic              write;
        logic              a64;
        logic [RID_W-1:0]  rid;
        logic              all_ok;
    } ctx_t;

    ctx_t ctx_d, ctx_q;

    logic [CNT_W-1:0]  total_bytes;
    logic [SIZE_W-1:0] cur_size;

    dps_byte_count #(
        .LEN_W (LEN_W),
        .CNT_W (CNT_W)
    ) u_count (
        .be     (req_be),
        .len_dw (req_len_dw),
        .total  (total_bytes)
    );

    dps_chunk_calc #(
        .ADDR_W     (ADDR_W),
        .PAGE_SHIFT (PAGE_SHIFT),
        .CNT_W      (CNT_W),
        .SIZE_W     (SIZE_W)
    ) u_calc (
        .addr   (ctx_q.addr),
        .remain (ctx_q.remain),
        .size   (cur_size)
    );

    always_comb begin
        ctx_d = ctx_q;
        unique case (ctx_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    ctx_d.addr   = req_addr;
                    ctx_d.remain = total_bytes;
                    ctx_d.write  = req_write;
                    ctx_d.a64    = req_addr64;
                    ctx_d.rid    = req_rid;
                    ctx_d.all_ok = 1'b1;
                    ctx_d.st     = (total_bytes == '0) ? ST_DONE : ST_ISSUE;
                end
            end
            ST_ISSUE: begin
                if (chunk_ready) begin
                    ctx_d.addr   = ctx_q.addr + ADDR_W'(cur_size);
                    ctx_d.remain = ctx_q.remain - CNT_W'(cur_size);
                    ctx_d.st     = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (rsp_valid) begin
                    ctx_d.all_ok = ctx_q.all_ok & rsp_ok;
                    ctx_d.st     = (ctx_q.remain == '0) ? ST_DONE : ST_ISSUE;
                end
            end
            ST_DONE: begin
                ctx_d.st = ST_IDLE;
            end
            default: ctx_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctx_q.st     <= ST_IDLE;
            ctx_q.addr   <= '0;
            ctx_q.remain <= '0;
            ctx_q.write  <= 1'b0;
            ctx_q.a64    <= 1'b0;
            ctx_q.rid    <= '0;
            ctx_q.all_ok <= 1'b1;
        end else begin
            ctx_q <= ctx_d;
        end
    end

    assign req_ready    = (ctx_q.st == ST_IDLE);
    assign chunk_valid  = (ctx_q.st == ST_ISSUE);
    assign chunk_write  = ctx_q.write;
    assign chunk_addr64 = ctx_q.a64;
    assign chunk_addr   = ctx_q.addr;
    assign chunk_bytes  = cur_size;
    assign chunk_rid    = ctx_q.rid;
    assign cpl_valid    = (ctx_q.st == ST_DONE);
    assign cpl_status   = ctx_q.all_ok ? CPL_SUCCESS : CPL_ABORT;

endmodule

// File: rtl/dps_checker.sv
module dps_checker #(
    parameter int ADDR_W     = 64,
    parameter int PAGE_SHIFT = 13,
    parameter int SIZE_W     = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              chunk_valid,
    input logic              chunk_ready,
    input logic [ADDR_W-1:0] chunk_addr,
    input logic [SIZE_W-1:0] chunk_bytes,
    input logic              rsp_valid,
    input logic              cpl_valid,
    input logic [2:0]        cpl_status
);
    logic              outstanding;
    logic [SIZE_W:0]   end_off;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            outstanding <= 1'b0;
        end else if (chunk_valid && chunk_ready) begin
            outstanding <= 1'b1;
        end else if (rsp_valid) begin
            outstanding <= 1'b0;
        end
    end

    assign end_off = (SIZE_W + 1)'(chunk_addr[PAGE_SHIFT-1:0]) + (SIZE_W + 1)'(chunk_bytes);

    AST_NO_PAGE_CROSS: assert property (@(posedge clk) disable iff (!rst_n)
        chunk_valid |-> (end_off <= ((SIZE_W + 1)'(1) << PAGE_SHIFT))); // R3

    AST_CHUNK_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        chunk_valid |-> (chunk_bytes != '0)); // R8

    AST_CHUNK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (chunk_valid && !chunk_ready) |=>
            (chunk_valid && $stable(chunk_addr) && $stable(chunk_bytes))); // R6

    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        outstanding |-> !chunk_valid); // R6

    AST_CPL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_valid |-> (cpl_status == 3'b000 || cpl_status == 3'b100)); // R7

    AST_CPL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_valid |=> (!cpl_valid && req_ready)); // R10

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (chunk_valid || outstanding) |-> !req_ready); // R9
endmodule

bind dma_page_splitter dps_checker #(
    .ADDR_W     (ADDR_W),
    .PAGE_SHIFT (PAGE_SHIFT),
    .SIZE_W     (SIZE_W)
) u_dps_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_ready   (req_ready),
    .chunk_valid (chunk_valid),
    .chunk_ready (chunk_ready),
    .chunk_addr  (chunk_addr),
    .chunk_bytes (chunk_bytes),
    .rsp_valid   (rsp_valid),
    .cpl_valid   (cpl_valid),
    .cpl_status  (cpl_status)
);

// File: tb/dma_page_splitter_bench.sv
`timescale 1ns/1ps
module dma_page_splitter_bench;
    localparam int ADDR_W = 64;
    localparam int LEN_W  = 10;
    localparam int RID_W  = 16;
    localparam int SIZE_W = 14;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic              req_write = 1'b0;
    logic              req_addr64 = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [LEN_W-1:0]  req_len_dw = '0;
    logic [7:0]        req_be = '0;
    logic [RID_W-1:0]  req_rid = '0;
    logic              chunk_valid;
    logic              chunk_ready = 1'b0;
    logic              chunk_write;
    logic              chunk_addr64;
    logic [ADDR_W-1:0] chunk_addr;
    logic [SIZE_W-1:0] chunk_bytes;
    logic [RID_W-1:0]  chunk_rid;
    logic              rsp_valid = 1'b0;
    logic              rsp_ok = 1'b0;
    logic              cpl_valid;
    logic [2:0]        cpl_status;

    always #5 clk = ~clk;

    dma_page_splitter u_dma_page_splitter (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr64(req_addr64), .req_addr(req_addr),
        .req_len_dw(req_len_dw), .req_be(req_be), .req_rid(req_rid),
        .chunk_valid(chunk_valid), .chunk_ready(chunk_ready),
        .chunk_write(chunk_write), .chunk_addr64(chunk_addr64),
        .chunk_addr(chunk_addr), .chunk_bytes(chunk_bytes), .chunk_rid(chunk_rid),
        .rsp_valid(rsp_valid), .rsp_ok(rsp_ok),
        .cpl_valid(cpl_valid), .cpl_status(cpl_status)
    );

    typedef struct {
        logic [63:0] addr;
        int          bytes;
    } exp_chunk_t;

    exp_chunk_t  exp_q[$];
    logic [2:0]  exp_cpl_q[$];
    int          n_checks = 0;
    int          n_fail = 0;
    logic        exp_write, exp_a64;
    logic [15:0] exp_rid;
    int          fail_idx = -1;
    int          chunk_idx = 0;
    int          stall_left = 0;
    int          cyc = 0;
    int          last_rsp_cyc = -10;
    bit          done = 0;
    bit          finished = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    // Driver: computes the expected chunks from the requirements and sends the request
    task automatic send_req(input bit wr, input bit a64, input logic [63:0] addr,
                            input int len, input logic [7:0] be, input logic [15:0] rid,
                            input int fidx, input int stall);
        int          cnt;
        logic [63:0] a;
        int          n;
        cnt = 0;
        for (int i = 0; i < 8; i++) cnt += be[i];          // R1
        if (len > 2) cnt += (len - 2) * 4;                 // R2
        a = addr;
        n = 0;
        while (cnt > 0) begin                              // R3
            int room;
            int sz;
            room = 8192 - int'(a % 64'd8192);
            sz   = (cnt < room) ? cnt : room;
            exp_q.push_back('{a, sz});
            a   += 64'(sz);
            cnt -= sz;
            n++;
        end
        exp_cpl_q.push_back((fidx >= 0 && fidx < n) ? 3'b100 : 3'b000);
        exp_write  = wr;
        exp_a64    = a64;
        exp_rid    = rid;
        fail_idx   = fidx;
        chunk_idx  = 0;
        stall_left = stall;
        done       = 0;
        @(negedge clk);
        check(req_ready == 1'b1, "R9", "req_ready when idle", req_ready, 1);
        req_write  = wr;
        req_addr64 = a64;
        req_addr   = addr;
        req_len_dw = LEN_W'(len);
        req_be     = be;
        req_rid    = rid;
        req_valid  = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (!done) @(negedge clk);
        @(negedge clk);
        check(cpl_valid == 1'b0, "R10", "completion is one cycle", cpl_valid, 0);
        check(req_ready == 1'b1, "R10", "ready after completion", req_ready, 1);
    endtask

    // Monitor: consumes chunks, answers them, and checks the completion
    initial begin
        bit          pend = 0;
        bit          held_v = 0;
        logic [63:0] held_addr = '0;
        forever begin
            @(negedge clk);
            cyc++;
            chunk_ready = 1'b0;
            rsp_valid   = 1'b0;
            if (rst_n) begin
                if (pend) begin
                    rsp_valid    = 1'b1;
                    rsp_ok       = (chunk_idx - 1 != fail_idx);
                    pend         = 0;
                    last_rsp_cyc = cyc;
                end else if (chunk_valid) begin
                    check(req_ready == 1'b0, "R9", "not ready while busy", req_ready, 0);
                    if (stall_left > 0) begin
                        stall_left--;
                        if (held_v)
                            check(chunk_addr == held_addr, "R6", "chunk held", chunk_addr, held_addr);
                        held_v    = 1;
                        held_addr = chunk_addr;
                    end else begin
                        if (held_v)
                            check(chunk_addr == held_addr, "R6", "chunk held", chunk_addr, held_addr);
                        held_v = 0;
                        if (exp_q.size() == 0) begin
                            check(0, "R8", "unexpected chunk", chunk_addr, 0);
                        end else begin
                            exp_chunk_t e;
                            e = exp_q.pop_front();
                            check(chunk_addr == e.addr, "R4", "chunk address", chunk_addr, e.addr);
                            check(int'(chunk_bytes) == e.bytes, "R3", "chunk bytes", chunk_bytes, e.bytes);
                            check(chunk_write == exp_write && chunk_addr64 == exp_a64 && chunk_rid == exp_rid,
                                  "R5", "chunk attributes", {chunk_write, chunk_addr64, chunk_rid},
                                  {exp_write, exp_a64, exp_rid});
                        end
                        chunk_ready = 1'b1;
                        pend = 1;
                        chunk_idx++;
                    end
                end
                if (cpl_valid) begin
                    logic [2:0] es;
                    es = (exp_cpl_q.size() > 0) ? exp_cpl_q.pop_front() : 3'b111;
                    check(cpl_status == es, "R7", "completion status", cpl_status, es);
                    check(exp_q.size() == 0, "R4", "all chunks issued", exp_q.size(), 0);
                    if (chunk_idx > 0)
                        check(cyc - last_rsp_cyc == 1, "R10", "completion timing", cyc - last_rsp_cyc, 1);
                    done = 1;
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1 && chunk_valid == 1'b0 && cpl_valid == 1'b0, "R9",
              "reset state", {req_ready, chunk_valid, cpl_valid}, 3'b100);
        // R2: aligned, one chunk of 16 bytes
        send_req(1'b0, 1'b0, 64'h0, 4, 8'hFF, 16'h0101, -1, 0);
        // R1: length 2, four bytes
        send_req(1'b1, 1'b0, 64'h40, 2, 8'h0F, 16'h0202, -1, 0);
        // R1: single byte, held for three cycles (R6)
        send_req(1'b0, 1'b1, 64'h1003, 1, 8'h01, 16'h0303, -1, 3);
        // R2: length 3 with sparse enables -> 6 bytes
        send_req(1'b1, 1'b0, 64'h2000, 3, 8'h11, 16'h0404, -1, 0);
        // R3: ends exactly on a page edge, single chunk of 8
        send_req(1'b0, 1'b0, 64'h1FF8, 2, 8'hFF, 16'h0505, -1, 0);
        // R3/R4: crosses an edge, 16 + 24
        send_req(1'b1, 1'b0, 64'h1FF0, 10, 8'hFF, 16'h0606, -1, 0);
        // R7: same split, second chunk fails
        send_req(1'b1, 1'b0, 64'h1FF0, 10, 8'hFF, 16'h0707, 1, 0);
        // R7: first chunk fails, second still issued
        send_req(1'b0, 1'b0, 64'h3FF0, 10, 8'hFF, 16'h0808, 0, 1);
        // R8: zero byte count
        send_req(1'b0, 1'b0, 64'h5000, 2, 8'h00, 16'h0909, -1, 0);
        // R5: 64-bit address, maximum length, 256 + 3836
        send_req(1'b1, 1'b1, 64'h0000_0012_3456_7F00, 1023, 8'hFF, 16'hBEEF, -1, 0);
        summary();
    end
endmodule